// File: doc/BRIEF.md
# Chained Hash Segment Sequencer

This block feeds a hash engine one segment at a time through a single register-write port. Each of two independent flows owns a table of up to eight descriptors. A descriptor holds a source address, a destination address and a byte count. When a flow is started, the block walks its table in order. For every segment it issues a burst of register writes and ends the burst with a control word that starts the engine. It then waits for the engine to report completion for that flow before it moves on to the next descriptor.

From the second segment on, the engine must continue from the intermediate digest of the previous segment. For this, the key-pointer and IV-pointer registers are both loaded with the previous segment's destination address, and a continuation bit is set in the control word.

Every wait is bounded by a cycle-count timeout. If the flow's status is still zero when the bound expires, the request ends with an error and no further segment is issued. The two flows share the port, and a burst from one flow is never interleaved with writes from the other.

Top module: `hseg_sequencer`

## Requirements
- R1: While reset is held and after it is released, no register write is issued and no request-done pulse appears until a flow is started.
- R2: The descriptor walk stops at the first entry whose destination address is zero, or after the eighth entry. A table whose first destination is zero ends at once with success and issues no writes.
- R3: A segment's burst writes register ids in this order: source (id 0), destination (id 1), length (id 2), interrupt enable (id 3), control (id 6). For chained segments, key pointer (id 4) and IV pointer (id 5) are written before the source.
- R4: The length written equals the descriptor byte count divided by four (a count of 32-bit words).
- R5: The interrupt-enable write carries the value 3, which enables both interrupt bits 0 and 1.
- R6: The control word has bit 0 set (start), the flow's method code in bits 5:2, and the flow index in bit 30. Bit 17 is set for every segment except the first.
- R7: For a chained segment, both the key-pointer write and the IV-pointer write carry the destination address of the previous segment.
- R8: The next segment is issued only after a completion pulse with a nonzero status. After the last segment, the block pulses the flow's request-done output with the error flag low.
- R9: If the status is still zero TIMEOUT_CYC cycles after the control write, the request-done pulse appears with the error flag high, TIMEOUT_CYC+1 cycles after the control write, and no further segment is issued.
- R10: A completion pulse that carries a zero status does not count as completion.
- R11: A flow's status is cleared in the cycle of its control write. A completion pulse received before that write cannot end the wait.
- R12: Bursts of the two flows never interleave. When both flows request the port, the flow not granted most recently goes first. Flow 0 goes first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | NFLOW | Per-flow start pulse, ignored while the flow is busy |
| method | input | NFLOW*MW | Per-flow algorithm method code, captured at start |
| desc_src | input | NFLOW*NDESC*AW | Descriptor source addresses |
| desc_dst | input | NFLOW*NDESC*AW | Descriptor destination addresses; zero ends the table |
| desc_bytes | input | NFLOW*NDESC*LW | Descriptor byte counts |
| eng_done | input | NFLOW | Per-flow engine completion pulse |
| eng_status | input | NFLOW*SW | Status value that comes with the completion pulse |
| wr_en | output | 1 | Register write strobe |
| wr_reg | output | 3 | Register id of the write |
| wr_data | output | DW | Write data |
| req_done | output | NFLOW | Per-flow request-finished pulse |
| req_err | output | NFLOW | Timeout flag, valid with req_done |

## Verification
The assertions assume that a flow's descriptor table and method input stay stable while that flow is busy. They also assume the engine pulses a flow's completion only after that flow's control write, except where a stale pulse is injected on purpose. The stimulus meets these assumptions. Tables are loaded before each start and left unchanged until the request-done pulse. The engine model in the bench answers only after it decodes a control write, at a fixed latency well below the timeout. The single stale pulse is sent while the flow is idle.

// File: rtl/hseg_pkg.sv
package hseg_pkg;

    localparam int NFLOW = 2;
    localparam int FW    = (NFLOW > 1) ? $clog2(NFLOW) : 1;

    typedef enum logic [2:0] {
        REG_SRC = 3'd0,
        REG_DST = 3'd1,
        REG_LEN = 3'd2,
        REG_IRQ = 3'd3,
        REG_KEY = 3'd4,
        REG_IV  = 3'd5,
        REG_CTL = 3'd6
    } reg_id_e;

    localparam int CTL_START_BIT  = 0;
    localparam int CTL_METHOD_LSB = 2;
    localparam int CTL_CHAIN_BIT  = 17;
    localparam int CTL_FLOW_LSB   = 30;
    localparam int IRQ_ENABLE_ALL = 3;

endpackage

// File: rtl/hseg_flow.sv
module hseg_flow #(
    parameter int AW          = 32,
    parameter int NDESC       = 8,
    parameter int LW          = 16,
    parameter int MW          = 4,
    parameter int SW          = 8,
    parameter int TIMEOUT_CYC = 200_000_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [MW-1:0]              method_in,
    input  logic [NDESC-1:0][AW-1:0]   desc_src,
    input  logic [NDESC-1:0][AW-1:0]   desc_dst,
    input  logic [NDESC-1:0][LW-1:0]   desc_bytes,
    input  logic                       eng_done,
    input  logic [SW-1:0]              eng_status,
    input  logic                       ctl_fire,
    output logic                       want,
    output logic [AW-1:0]              seg_src,
    output logic [AW-1:0]              seg_dst,
    output logic [LW-1:0]              seg_bytes,
    output logic [AW-1:0]              seg_prev,
    output logic                       seg_chain,
    output logic [MW-1:0]              seg_method,
    output logic                       req_done,
    output logic                       req_err
);

    localparam int IW = $clog2(NDESC + 1);
    localparam int XW = (NDESC > 1) ? $clog2(NDESC) : 1;
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    typedef enum logic [1:0] {F_IDLE, F_EVAL, F_WANT, F_WAIT} fstate_e;

    typedef struct packed {
        fstate_e         state;
        logic [IW-1:0]   idx;
        logic [MW-1:0]   method;
        logic [AW-1:0]   prev;
        logic [SW-1:0]   status;
        logic [CW-1:0]   cnt;
        logic            done;
        logic            err;
    } flow_t;

    flow_t q, d;
    logic [XW-1:0] ix;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        ix     = q.idx[XW-1:0];

        if (ctl_fire) begin
            d.status = '0;
        end else if (eng_done) begin
            d.status = eng_status;
        end

        case (q.state)
            F_IDLE: begin
                if (start) begin
                    d.idx    = '0;
                    d.method = method_in;
                    d.state  = F_EVAL;
                end
            end
            F_EVAL: begin
                if (q.idx == IW'(NDESC) || desc_dst[ix] == '0) begin
                    d.done  = 1'b1;
                    d.state = F_IDLE;
                end else begin
                    d.state = F_WANT;
                end
            end
            F_WANT: begin
                if (ctl_fire) begin
                    d.cnt   = '0;
                    d.state = F_WAIT;
                end
            end
            F_WAIT: begin
                if (q.status != '0) begin
                    d.prev  = desc_dst[ix];
                    d.idx   = q.idx + 1'b1;
                    d.state = F_EVAL;
                end else if (q.cnt == CW'(TIMEOUT_CYC - 1)) begin
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                    d.state = F_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.state = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign want       = (q.state == F_WANT);
    assign seg_src    = desc_src[q.idx[XW-1:0]];
    assign seg_dst    = desc_dst[q.idx[XW-1:0]];
    assign seg_bytes  = desc_bytes[q.idx[XW-1:0]];
    assign seg_prev   = q.prev;
    assign seg_chain  = (q.idx != '0);
    assign seg_method = q.method;
    assign req_done   = q.done;
    assign req_err    = q.err;

    // R11: the writer fires a control write only for a flow that is waiting for the port
    a_r11_fire_only_when_wanting: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_fire |-> (q.state == F_WANT));

    // R10: without a nonzero status and before the limit, the wait continues
    a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == F_WAIT && q.status == '0 && q.cnt != CW'(TIMEOUT_CYC - 1))
        |=> (q.state == F_WAIT));

    // R9: an error pulse only follows a wait
    a_r9_err_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && req_err) |-> $past(q.state == F_WAIT));

endmodule

// File: rtl/hseg_arb.sv
module hseg_arb
    import hseg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLOW-1:0] want,
    input  logic             busy,
    output logic             gnt_valid,
    output logic [FW-1:0]    gnt_idx
);

    typedef struct packed {
        logic [FW-1:0] last;
    } arb_t;

    arb_t q, d;
    logic [NFLOW-1:0] gnt_vec;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        gnt_vec   = '0;
        for (int k = 1; k <= NFLOW; k++) begin
            int cand;
            cand = (int'(q.last) + k) % NFLOW;
            if (!busy && !gnt_valid && want[cand]) begin
                gnt_valid     = 1'b1;
                gnt_idx       = FW'(cand);
                gnt_vec[cand] = 1'b1;
            end
        end
        d = q;
        if (gnt_valid) begin
            d.last = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.last <= FW'(NFLOW - 1);
        end else begin
            q <= d;
        end
    end

    // R12: at most one flow holds the port and only one that asked for it
    a_r12_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec));
    a_r12_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> want[gnt_idx]);

endmodule

// File: rtl/hseg_writer.sv
module hseg_writer
    import hseg_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int MW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt_valid,
    input  logic [FW-1:0]    gnt_idx,
    input  logic [AW-1:0]    seg_src,
    input  logic [AW-1:0]    seg_dst,
    input  logic [LW-1:0]    seg_bytes,
    input  logic [AW-1:0]    seg_prev,
    input  logic             seg_chain,
    input  logic [MW-1:0]    seg_method,
    output logic             busy,
    output logic [FW-1:0]    sel_idx,
    output logic             wr_en,
    output logic [2:0]       wr_reg,
    output logic [DW-1:0]    wr_data,
    output logic [NFLOW-1:0] ctl_fire
);

    typedef struct packed {
        logic          busy;
        logic [FW-1:0] owner;
        reg_id_e       step;
    } wr_t;

    wr_t q, d;
    logic [DW-1:0] ctl_word;

    assign sel_idx = q.busy ? q.owner : gnt_idx;

    always_comb begin
        ctl_word                                  = '0;
        ctl_word[CTL_START_BIT]                   = 1'b1;
        ctl_word[CTL_METHOD_LSB +: MW]            = seg_method;
        ctl_word[CTL_CHAIN_BIT]                   = seg_chain;
        ctl_word[CTL_FLOW_LSB +: FW]              = q.owner;
    end

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (gnt_valid) begin
                d.busy  = 1'b1;
                d.owner = gnt_idx;
                d.step  = seg_chain ? REG_KEY : REG_SRC;
            end
        end else begin
            case (q.step)
                REG_KEY: d.step = REG_IV;
                REG_IV:  d.step = REG_SRC;
                REG_SRC: d.step = REG_DST;
                REG_DST: d.step = REG_LEN;
                REG_LEN: d.step = REG_IRQ;
                REG_IRQ: d.step = REG_CTL;
                default: d.busy = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, owner: '0, step: REG_SRC};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        wr_en    = q.busy;
        wr_reg   = q.step;
        ctl_fire = '0;
        case (q.step)
            REG_SRC: wr_data = DW'(seg_src);
            REG_DST: wr_data = DW'(seg_dst);
            REG_LEN: wr_data = DW'(seg_bytes >> 2);
            REG_IRQ: wr_data = DW'(IRQ_ENABLE_ALL);
            REG_KEY: wr_data = DW'(seg_prev);
            REG_IV:  wr_data = DW'(seg_prev);
            default: wr_data = ctl_word;
        endcase
        if (q.busy && q.step == REG_CTL) begin
            ctl_fire[q.owner] = 1'b1;
        end
    end

    assign busy = q.busy;

    // R12: a burst ends with its control write and the port then rests a cycle
    a_r12_burst_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_CTL) |=> !wr_en);

    // R3: source is followed directly by destination, then length
    a_r3_src_then_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_SRC) |=> (wr_en && wr_reg == REG_DST));
    a_r3_dst_then_len: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_DST) |=> (wr_en && wr_reg == REG_LEN));

    // R7: key and IV pointers carry the same address, back to back
    a_r7_key_iv_same: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_KEY) |=> (wr_en && wr_reg == REG_IV && $stable(wr_data)));

endmodule

// File: rtl/hseg_sequencer.sv
module hseg_sequencer
    import hseg_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int NDESC       = 8,
    parameter int LW          = 16,
    parameter int MW          = 4,
    parameter int SW          = 8,
    parameter int TIMEOUT_CYC = 200_000_000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NFLOW-1:0]                      start,
    input  logic [NFLOW-1:0][MW-1:0]              method,
    input  logic [NFLOW-1:0][NDESC-1:0][AW-1:0]   desc_src,
    input  logic [NFLOW-1:0][NDESC-1:0][AW-1:0]   desc_dst,
    input  logic [NFLOW-1:0][NDESC-1:0][LW-1:0]   desc_bytes,
    input  logic [NFLOW-1:0]                      eng_done,
    input  logic [NFLOW-1:0][SW-1:0]              eng_status,
    output logic                                  wr_en,
    output logic [2:0]                            wr_reg,
    output logic [DW-1:0]                         wr_data,
    output logic [NFLOW-1:0]                      req_done,
    output logic [NFLOW-1:0]                      req_err
);

    logic [NFLOW-1:0]          f_want;
    logic [NFLOW-1:0][AW-1:0]  f_src;
    logic [NFLOW-1:0][AW-1:0]  f_dst;
    logic [NFLOW-1:0][LW-1:0]  f_bytes;
    logic [NFLOW-1:0][AW-1:0]  f_prev;
    logic [NFLOW-1:0]          f_chain;
    logic [NFLOW-1:0][MW-1:0]  f_method;
    logic [NFLOW-1:0]          ctl_fire;

    logic          busy;
    logic          gnt_valid;
    logic [FW-1:0] gnt_idx;
    logic [FW-1:0] sel_idx;

    for (genvar g = 0; g < NFLOW; g++) begin : g_flow
        hseg_flow #(
            .AW(AW), .NDESC(NDESC), .LW(LW), .MW(MW), .SW(SW),
            .TIMEOUT_CYC(TIMEOUT_CYC)
        ) i_flow (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start[g]),
            .method_in  (method[g]),
            .desc_src   (desc_src[g]),
            .desc_dst   (desc_dst[g]),
            .desc_bytes (desc_bytes[g]),
            .eng_done   (eng_done[g]),
            .eng_status (eng_status[g]),
            .ctl_fire   (ctl_fire[g]),
            .want       (f_want[g]),
            .seg_src    (f_src[g]),
            .seg_dst    (f_dst[g]),
            .seg_bytes  (f_bytes[g]),
            .seg_prev   (f_prev[g]),
            .seg_chain  (f_chain[g]),
            .seg_method (f_method[g]),
            .req_done   (req_done[g]),
            .req_err    (req_err[g])
        );
    end

    hseg_arb i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (f_want),
        .busy      (busy),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    hseg_writer #(.AW(AW), .DW(DW), .LW(LW), .MW(MW)) i_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_valid  (gnt_valid),
        .gnt_idx    (gnt_idx),
        .seg_src    (f_src[sel_idx]),
        .seg_dst    (f_dst[sel_idx]),
        .seg_bytes  (f_bytes[sel_idx]),
        .seg_prev   (f_prev[sel_idx]),
        .seg_chain  (f_chain[sel_idx]),
        .seg_method (f_method[sel_idx]),
        .busy       (busy),
        .sel_idx    (sel_idx),
        .wr_en      (wr_en),
        .wr_reg     (wr_reg),
        .wr_data    (wr_data),
        .ctl_fire   (ctl_fire)
    );

    // R1: no write strobe while reset is applied
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !wr_en);

endmodule

// File: tb/test_hseg_sequencer.sv
module test_hseg_sequencer;

    localparam int NF  = 2;
    localparam int ND  = 8;
    localparam int TO  = 60;
    localparam int LAT = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NF-1:0]                 start = '0;
    logic [NF-1:0][3:0]            method = '0;
    logic [NF-1:0][ND-1:0][31:0]   desc_src = '0;
    logic [NF-1:0][ND-1:0][31:0]   desc_dst = '0;
    logic [NF-1:0][ND-1:0][15:0]   desc_bytes = '0;
    logic [NF-1:0]                 eng_done = '0;
    logic [NF-1:0][7:0]            eng_status = '0;
    logic                          wr_en;
    logic [2:0]                    wr_reg;
    logic [31:0]                   wr_data;
    logic [NF-1:0]                 req_done;
    logic [NF-1:0]                 req_err;

    always #5 clk = ~clk;

    hseg_sequencer #(.TIMEOUT_CYC(TO)) i_hseg_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .method(method),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_bytes(desc_bytes),
        .eng_done(eng_done), .eng_status(eng_status),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
        .req_done(req_done), .req_err(req_err)
    );

    typedef struct {
        logic [2:0]  r;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mode = 0;           // 0: answer status 1, 1: silent, 2: answer status 0
    int last_ctl_cyc [NF];
    int done_count [NF];
    logic done_err_v [NF];
    int done_cyc [NF];
    bit finished = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic push(logic [2:0] r, logic [31:0] d, string tag);
        exp_t e;
        e.r = r; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    function automatic logic [31:0] ctl_exp(int f, logic [3:0] m, bit chain);
        return 32'd1 | (32'(m) << 2) | (32'(chain) << 17) | (32'(f) << 30);
    endfunction

    task automatic push_seg(int f, int i);
        if (i > 0) begin
            push(3'd4, desc_dst[f][i-1], "R7");
            push(3'd5, desc_dst[f][i-1], "R7");
        end
        push(3'd0, desc_src[f][i], "R3");
        push(3'd1, desc_dst[f][i], "R3");
        push(3'd2, 32'(desc_bytes[f][i]) >> 2, "R4");
        push(3'd3, 32'd3, "R5");
        push(3'd6, ctl_exp(f, method[f], i > 0), "R6");
    endtask

    task automatic fill(int f, int n);
        for (int i = 0; i < ND; i++) begin
            desc_src[f][i]   = (i < n) ? 32'h1000_0000 + (f << 20) + i * 32'h100 : 32'h0;
            desc_dst[f][i]   = (i < n) ? 32'h2000_0000 + (f << 20) + i * 32'h40 : 32'h0;
            desc_bytes[f][i] = 16'(64 * (i + 1) + 4 * f);
        end
    endtask

    task automatic reply(int f, logic [7:0] st);
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        eng_done[f] = 1'b1;
        eng_status[f] = st;
        @(negedge clk);
        eng_done[f] = 1'b0;
        eng_status[f] = 8'h0;
    endtask

    // monitor: compares every write against the scoreboard, models the engine
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected write reg", wr_reg, 7);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(wr_reg == e.r, e.tag, "write reg", wr_reg, e.r);
                    check(wr_data == e.d, e.tag, "write data", wr_data, e.d);
                end
                if (wr_reg == 3'd6) begin
                    int f;
                    f = int'(wr_data[30]);
                    last_ctl_cyc[f] = cyc;
                    if (mode == 0) fork reply(f, 8'h01); join_none
                    else if (mode == 2) fork reply(f, 8'h00); join_none
                end
            end
            for (int f = 0; f < NF; f++) begin
                if (req_done[f]) begin
                    done_count[f]++;
                    done_err_v[f] = req_err[f];
                    done_cyc[f] = cyc;
                end
            end
        end
    end

    always @(posedge clk) cyc++;

    task automatic start_flows(logic [NF-1:0] which);
        @(negedge clk);
        start = which;
        @(negedge clk);
        start = '0;
    endtask

    task automatic wait_done(int f, int base, bit exp_err, string tag);
        int n = 0;
        while (done_count[f] == base && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done_count[f] != base, tag, "request done seen", done_count[f] - base, 1);
        check(done_err_v[f] == exp_err, tag, "error flag", done_err_v[f], exp_err);
    endtask

    initial begin
        for (int f = 0; f < NF; f++) begin
            done_count[f] = 0; last_ctl_cyc[f] = 0; done_cyc[f] = 0; done_err_v[f] = 0;
        end
        repeat (3) @(negedge clk);
        check(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(wr_en == 1'b0, "R1", "wr_en after reset", wr_en, 0);
        check(req_done == '0, "R1", "req_done after reset", req_done, 0);

        // R2 R3 R6 R7 R8: flow 0, three chained segments
        begin
            int b;
            fill(0, 3); method[0] = 4'h5; mode = 0;
            for (int i = 0; i < 3; i++) push_seg(0, i);
            b = done_count[0];
            start_flows(2'b01);
            wait_done(0, b, 0, "R8");
            check(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);
        end

        // R2: flow 1, full table of eight entries
        begin
            int b;
            fill(1, ND); method[1] = 4'hA; mode = 0;
            for (int i = 0; i < ND; i++) push_seg(1, i);
            b = done_count[1];
            start_flows(2'b10);
            wait_done(1, b, 0, "R2");
            check(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);
        end

        // R2: empty table finishes at once without writes
        begin
            int b;
            fill(0, 0);
            b = done_count[0];
            start_flows(2'b01);
            wait_done(0, b, 0, "R2");
            repeat (5) @(negedge clk);
            check(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);
        end

        // R9: silent engine, timeout after the first segment
        begin
            int b;
            fill(0, 2); method[0] = 4'h3; mode = 1;
            push_seg(0, 0);
            b = done_count[0];
            start_flows(2'b01);
            wait_done(0, b, 1, "R9");
            check(done_cyc[0] - last_ctl_cyc[0] == TO + 1, "R9", "timeout latency",
                  done_cyc[0] - last_ctl_cyc[0], TO + 1);
            repeat (30) @(negedge clk);
            check(exp_q.size() == 0, "R9", "pending writes", exp_q.size(), 0);
        end

        // R10: completion carrying zero status is not completion
        begin
            int b;
            fill(1, 2); method[1] = 4'h7; mode = 2;
            push_seg(1, 0);
            b = done_count[1];
            start_flows(2'b10);
            wait_done(1, b, 1, "R10");
            repeat (10) @(negedge clk);
            check(exp_q.size() == 0, "R10", "pending writes", exp_q.size(), 0);
        end

        // R11: stale completion before the control write is discarded
        begin
            int b;
            fill(0, 1); method[0] = 4'h1; mode = 1;
            reply(0, 8'h01);
            push_seg(0, 0);
            b = done_count[0];
            start_flows(2'b01);
            wait_done(0, b, 1, "R11");
            check(done_cyc[0] - last_ctl_cyc[0] == TO + 1, "R11", "wait length",
                  done_cyc[0] - last_ctl_cyc[0], TO + 1);
        end

        // R12: both flows at once; flow 0 was granted last, so flow 1 goes first
        begin
            int b0, b1;
            fill(0, 2); fill(1, 1); method[0] = 4'h2; method[1] = 4'h9; mode = 0;
            push_seg(1, 0);
            push_seg(0, 0);
            push_seg(0, 1);
            b0 = done_count[0]; b1 = done_count[1];
            start_flows(2'b11);
            wait_done(1, b1, 0, "R12");
            wait_done(0, b0, 0, "R12");
            repeat (5) @(negedge clk);
            check(exp_q.size() == 0, "R12", "pending writes", exp_q.size(), 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule